// File: doc/BRIEF.md
# Multi-channel edge-aligned PWM timer

This block is a timer that produces several pulse-width-modulated outputs from one shared up-counter. A power-of-two prescaler sets the rate at which the counter advances. A period register sets the count at which it wraps back to zero. Each channel has its own compare value and a small control register that picks the output waveform. Software reaches all of this through a plain synchronous register port with a registered read path.

While the counter is stopped, a write to the period register or to a compare register takes effect on the next clock. While it runs, such writes go to a holding copy and are copied into the working value on the clock where the counter wraps. A change in duty or period therefore never splits a pulse. The channel mode bits are not held in this way: a change to a channel's enable or polarity shows at its output on the next clock. Each channel also keeps a sticky flag that is set when the counter steps at the channel's compare value. Software clears it by writing a one to bit 7.

Register offsets are byte addresses: 0x04 channel count, 0x08 reserved, 0x10 configuration, 0x14 count, 0x18 period, and for channel n the control register at 0x20+8n and the compare register at 0x24+8n. Any other address reads zero and ignores writes.

Top module: `lp_pwm_timer`

## Requirements
- R1: A read of offset 0x04 returns the number of channels in bits [7:0] and zero above. Offset 0x08 and any unmapped offset read zero.
- R2: The configuration register holds the prescale exponent in bits [2:0] and the run mode in bits [4:3]. Bit 5 is not stored and always reads 0.
- R3: With run mode 00 the count holds its value. With any other mode the count advances once every 2^exponent clocks.
- R4: The count steps from 0 up to the active period and then returns to 0, so one period lasts period+1 steps. A count already at or above the active period also returns to 0 on its next step.
- R5: A configuration write that moves the run mode from 00 to non-zero clears the count and the prescale phase. Any write to offset 0x14 clears the count.
- R6: While the run mode is 00, a write to the period or to a compare register updates both the working value and the value read back.
- R7: While the counter runs, period and compare writes change only the read-back value. The working value takes it on the step where the count returns to 0.
- R8: A channel whose control bit 5 is 1 with level code 10 in bits [3:2] drives 1 while count < compare, one clock after the state that produced it. Compare 0 gives a constant 0, and compare above the period gives a constant 1.
- R9: With bit 5 set and level code 01, the output is the complement of the R8 waveform.
- R10: A channel with bit 5 clear, or with level code 00 or 11, drives 0. All outputs are 0 after reset.
- R11: Control bits 5, 4 and [3:2] take effect on the clock after the write, with no wait for the period boundary.
- R12: Control bit 7 is set on any step taken while count equals the working compare. Writing 1 to bit 7 clears it, and a set in the same cycle wins. Writing 0 to bit 7 leaves it unchanged.
- R13: Read data is registered. It appears on the clock after a cycle with rd_en high, holds while rd_en is low, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; captures read data at the clock edge |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| pwm_out | output | NCH | Registered PWM output, one bit per channel |

## Verification
The checker assumes that wr_en and rd_en are never unknown once reset is released. It also assumes that reset is high from time zero until the first few clock edges. Its properties that involve a write are guarded by "no write this cycle", and they allow for a read and a write to different registers in the same cycle. The stimulus issues at most one register access per cycle and holds the strobes low when idle. It drives every input on the falling clock edge, so each property sees stable values. Period changes while running, a prescale change mid-period, stop/start and a count clear are all issued through the normal port.

// File: rtl/lp_pwm_pkg.sv
package lp_pwm_pkg;

  localparam int unsigned OFS_INFO   = 'h04;
  localparam int unsigned OFS_RSVD   = 'h08;
  localparam int unsigned OFS_CFG    = 'h10;
  localparam int unsigned OFS_COUNT  = 'h14;
  localparam int unsigned OFS_PERIOD = 'h18;
  localparam int unsigned OFS_CH0    = 'h20;
  localparam int unsigned CH_STRIDE  = 8;

  localparam int CTL_FLAG_BIT = 7;
  localparam int CTL_HI_BIT   = 5;
  localparam int CTL_LO_BIT   = 4;
  localparam int CTL_LVL_LSB  = 2;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_INV  = 2'b01,
    LVL_NORM = 2'b10,
    LVL_RSVD = 2'b11
  } lvl_sel_e;

  typedef struct packed {
    logic     flag;
    logic     mode_hi;
    logic     mode_lo;
    lvl_sel_e lvl;
  } ch_ctl_t;

  function automatic int unsigned ofs_ch_ctl(int unsigned n);
    return OFS_CH0 + CH_STRIDE * n;
  endfunction

  function automatic int unsigned ofs_ch_cmp(int unsigned n);
    return OFS_CH0 + CH_STRIDE * n + 4;
  endfunction

endpackage

// File: rtl/lp_pwm_prescale.sv
module lp_pwm_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] limit;

  always_comb begin
    span  = {{DIV_W{1'b0}}, 1'b1} << ps;
    limit = DIV_W'(span - 1'b1);
    tick  = run && (phase_q >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) phase_q <= '0;
    else if (tick)   phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

endmodule

// File: rtl/lp_pwm_counter.sv
module lp_pwm_counter #(
  parameter int              CNT_W      = 16,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic             clr,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] per_act_q,
  output logic [CNT_W-1:0] per_buf_q,
  output logic             wrap
);
  assign wrap = tick && (cnt_q >= per_act_q);

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (restart || clr)  cnt_q <= '0;
    else if (tick)            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_buf_q <= PERIOD_RST;
      per_act_q <= PERIOD_RST;
    end else begin
      if (per_wr) per_buf_q <= per_wdata;
      if (per_wr && !run) per_act_q <= per_wdata;
      else if (wrap)      per_act_q <= per_buf_q;
    end
  end

endmodule

// File: rtl/lp_pwm_channel.sv
module lp_pwm_channel import lp_pwm_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ctl_wr,
  input  logic             flag_clr,
  input  logic             mode_hi_d,
  input  logic             mode_lo_d,
  input  logic [1:0]       lvl_d,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output ch_ctl_t          ctl_q,
  output logic [CNT_W-1:0] cmp_buf_q,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cmp_act_q;
  logic             hit;
  logic             below;

  assign hit   = tick && (cnt == cmp_act_q);
  assign below = cnt < cmp_act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '{flag: 1'b0, mode_hi: 1'b0, mode_lo: 1'b0, lvl: LVL_OFF};
    end else begin
      ctl_q.flag <= hit || (ctl_q.flag && !(ctl_wr && flag_clr));
      if (ctl_wr) begin
        ctl_q.mode_hi <= mode_hi_d;
        ctl_q.mode_lo <= mode_lo_d;
        ctl_q.lvl     <= lvl_sel_e'(lvl_d);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_buf_q <= '0;
      cmp_act_q <= '0;
    end else begin
      if (cmp_wr) cmp_buf_q <= cmp_wdata;
      if (cmp_wr && !run) cmp_act_q <= cmp_wdata;
      else if (wrap)      cmp_act_q <= cmp_buf_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else if (ctl_q.mode_hi && ctl_q.lvl == LVL_NORM) pwm_o <= below;
    else if (ctl_q.mode_hi && ctl_q.lvl == LVL_INV)  pwm_o <= !below;
    else pwm_o <= 1'b0;
  end

endmodule

// File: rtl/lp_pwm_timer.sv
module lp_pwm_timer import lp_pwm_pkg::*; #(
  parameter int               NCH        = 4,
  parameter int               CNT_W      = 16,
  parameter int               PS_W       = 3,
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 16,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam logic [ADDR_W-1:0] A_INFO   = ADDR_W'(OFS_INFO);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFS_PERIOD);
  localparam int MODE_LSB = PS_W;

  logic [PS_W-1:0]  ps_q;
  logic [1:0]       cmod_q;
  logic             run, restart, tick, wrap;
  logic             cfg_wr, cnt_wr, per_wr;
  logic [CNT_W-1:0] cnt_q, per_act_q, per_buf_q;
  logic [NCH-1:0]   ctl_wr, cmp_wr, ch_msb;
  logic [7:0]       ctl_rd [NCH];
  logic [CNT_W-1:0] cmp_rd [NCH];
  logic [DATA_W-1:0] rd_mux;

  assign cfg_wr  = wr_en && (addr == A_CFG);
  assign cnt_wr  = wr_en && (addr == A_COUNT);
  assign per_wr  = wr_en && (addr == A_PERIOD);
  assign run     = |cmod_q;
  assign restart = cfg_wr && (|wdata[MODE_LSB+1:MODE_LSB]) && !run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q   <= '0;
      cmod_q <= 2'b00;
    end else if (cfg_wr) begin
      ps_q   <= wdata[PS_W-1:0];
      cmod_q <= wdata[MODE_LSB+1:MODE_LSB];
    end
  end

  lp_pwm_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .ps(ps_q), .tick(tick)
  );

  lp_pwm_counter #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .restart(restart), .tick(tick),
    .clr(cnt_wr), .per_wr(per_wr), .per_wdata(wdata[CNT_W-1:0]),
    .cnt_q(cnt_q), .per_act_q(per_act_q), .per_buf_q(per_buf_q), .wrap(wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ofs_ch_ctl(g));
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(ofs_ch_cmp(g));
    ch_ctl_t ctl;

    assign ctl_wr[g] = wr_en && (addr == A_CTL);
    assign cmp_wr[g] = wr_en && (addr == A_CMP);

    lp_pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .run(run), .tick(tick), .wrap(wrap), .cnt(cnt_q),
      .ctl_wr(ctl_wr[g]), .flag_clr(wdata[CTL_FLAG_BIT]),
      .mode_hi_d(wdata[CTL_HI_BIT]), .mode_lo_d(wdata[CTL_LO_BIT]),
      .lvl_d(wdata[CTL_LVL_LSB+1:CTL_LVL_LSB]),
      .cmp_wr(cmp_wr[g]), .cmp_wdata(wdata[CNT_W-1:0]),
      .ctl_q(ctl), .cmp_buf_q(cmp_rd[g]), .pwm_o(pwm_out[g])
    );

    assign ch_msb[g] = ctl.mode_hi;
    assign ctl_rd[g] = {ctl.flag, 1'b0, ctl.mode_hi, ctl.mode_lo, ctl.lvl, 2'b00};
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_INFO)   rd_mux = DATA_W'(NCH);
    if (addr == A_CFG)    rd_mux = DATA_W'({cmod_q, ps_q});
    if (addr == A_COUNT)  rd_mux = DATA_W'(cnt_q);
    if (addr == A_PERIOD) rd_mux = DATA_W'(per_buf_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(ofs_ch_ctl(i))) rd_mux = DATA_W'(ctl_rd[i]);
      if (addr == ADDR_W'(ofs_ch_cmp(i))) rd_mux = DATA_W'(cmp_rd[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/lp_pwm_timer_chk.sv
module lp_pwm_timer_chk import lp_pwm_pkg::*; #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [NCH-1:0]    pwm_out,
  input logic              run,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  per_act_q,
  input logic [NCH-1:0]    ch_msb
);
  localparam logic [ADDR_W-1:0] A_INFO   = ADDR_W'(OFS_INFO);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFS_PERIOD);

  p_info_read_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_INFO) |=> rdata == DATA_W'(NCH));

  p_stop_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable(cnt_q));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q >= per_act_q && !wr_en) |=> cnt_q == '0);

  p_start_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(run)) |-> cnt_q == '0);

  p_stopped_period_r6: assert property (@(posedge clk) disable iff (rst)
    (!run && wr_en && addr == A_PERIOD) |=> per_act_q == $past(wdata[CNT_W-1:0]));

  p_read_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  for (genvar g = 0; g < NCH; g++) begin : g_off
    p_disabled_low_r10: assert property (@(posedge clk) disable iff (rst)
      !ch_msb[g] |=> !pwm_out[g]);
  end

endmodule

bind lp_pwm_timer lp_pwm_timer_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .run(run), .tick(tick),
  .cnt_q(cnt_q), .per_act_q(per_act_q), .ch_msb(ch_msb)
);

// File: tb/lp_pwm_timer_bench.sv
module lp_pwm_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int A_INFO = 'h04, A_RSVD = 'h08, A_CFG = 'h10, A_CNT = 'h14, A_PER = 'h18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [NCH-1:0] pwm_out;

  int vectors = 0, miscompares = 0;
  string cur_req = "R13";

  int m_ps, m_cmod, m_cnt, m_pre, m_per_buf, m_per_act;
  int m_cmp_buf [NCH], m_cmp_act [NCH], m_hi [NCH], m_lo [NCH], m_lvl [NCH], m_flag [NCH];
  logic [NCH-1:0] m_out;
  int m_rdata;

  lp_pwm_timer u_lp_pwm_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int a_ctl(int n); return 'h20 + 8*n; endfunction
  function automatic int a_cmp(int n); return 'h24 + 8*n; endfunction

  task automatic model_reset();
    m_ps = 0; m_cmod = 0; m_cnt = 0; m_pre = 0; m_per_buf = 65535; m_per_act = 65535;
    for (int i = 0; i < NCH; i++) begin
      m_cmp_buf[i] = 0; m_cmp_act[i] = 0; m_hi[i] = 0; m_lo[i] = 0; m_lvl[i] = 0; m_flag[i] = 0;
    end
    m_out = '0; m_rdata = 0;
  endtask

  function automatic int rd_value(int a);
    int v = 0;
    if (a == A_INFO) v = NCH;
    if (a == A_CFG)  v = m_cmod * 8 + m_ps;
    if (a == A_CNT)  v = m_cnt;
    if (a == A_PER)  v = m_per_buf;
    for (int i = 0; i < NCH; i++) begin
      if (a == a_ctl(i)) v = m_flag[i]*128 + m_hi[i]*32 + m_lo[i]*16 + m_lvl[i]*4;
      if (a == a_cmp(i)) v = m_cmp_buf[i];
    end
    return v;
  endfunction

  task automatic check(int act, int exp, string req, string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycle(bit we, bit re, int a, int d);
    bit run, tick, wrap, below;
    int n_cnt, n_pre, n_per_act, n_rdata;
    int n_cmp_act [NCH];
    int n_flag [NCH];
    logic [NCH-1:0] n_out;
    wr_en = we; rd_en = re; addr = ADDR_W'(a); wdata = DATA_W'(d);
    run  = (m_cmod != 0);
    tick = run && (m_pre >= (1 << m_ps) - 1);
    wrap = tick && (m_cnt >= m_per_act);
    n_rdata = re ? rd_value(a) : m_rdata;
    n_pre = !run ? 0 : (tick ? 0 : m_pre + 1);
    if ((we && a == A_CFG && !run && ((d >> 3) & 3) != 0) || (we && a == A_CNT)) n_cnt = 0;
    else if (tick) n_cnt = wrap ? 0 : m_cnt + 1;
    else n_cnt = m_cnt;
    n_per_act = m_per_act;
    if (we && a == A_PER && !run) n_per_act = d & 'hFFFF;
    else if (wrap) n_per_act = m_per_buf;
    for (int i = 0; i < NCH; i++) begin
      below = (m_cnt < m_cmp_act[i]);
      if (m_hi[i] == 1 && m_lvl[i] == 2)      n_out[i] = below;
      else if (m_hi[i] == 1 && m_lvl[i] == 1) n_out[i] = !below;
      else                                    n_out[i] = 1'b0;
      n_flag[i] = (tick && m_cnt == m_cmp_act[i]) ? 1 :
                  ((we && a == a_ctl(i) && d[7]) ? 0 : m_flag[i]);
      n_cmp_act[i] = m_cmp_act[i];
      if (we && a == a_cmp(i) && !run) n_cmp_act[i] = d & 'hFFFF;
      else if (wrap) n_cmp_act[i] = m_cmp_buf[i];
    end
    @(posedge clk);
    @(negedge clk);
    m_pre = n_pre; m_cnt = n_cnt; m_per_act = n_per_act; m_rdata = n_rdata; m_out = n_out;
    if (we && a == A_CFG) begin m_ps = d & 7; m_cmod = (d >> 3) & 3; end
    if (we && a == A_PER) m_per_buf = d & 'hFFFF;
    for (int i = 0; i < NCH; i++) begin
      m_flag[i] = n_flag[i]; m_cmp_act[i] = n_cmp_act[i];
      if (we && a == a_cmp(i)) m_cmp_buf[i] = d & 'hFFFF;
      if (we && a == a_ctl(i)) begin
        m_hi[i] = (d >> 5) & 1; m_lo[i] = (d >> 4) & 1; m_lvl[i] = (d >> 2) & 3;
      end
    end
    wr_en = 1'b0; rd_en = 1'b0;
    vectors++;
    if (pwm_out !== m_out || int'(rdata) != m_rdata) begin
      miscompares++;
      $display("FAIL %s pwm_out/rdata: actual=%b/%0d expected=%b/%0d",
               cur_req, pwm_out, rdata, m_out, m_rdata);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cycle(0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int c1, c2;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(int'(pwm_out), 0, "R10", "outputs after reset");
    check(int'(rdata), 0, "R13", "read data after reset");

    cur_req = "R1";
    cycle(0, 1, A_INFO, 0); check(int'(rdata), NCH, "R1", "channel count");
    cycle(0, 1, A_RSVD, 0); check(int'(rdata), 0, "R1", "reserved offset");
    cycle(0, 1, 'h7C, 0);   check(int'(rdata), 0, "R1", "unmapped offset");

    cur_req = "R6";
    cycle(1, 0, A_PER, 9);
    cycle(1, 0, a_cmp(0), 3);
    cycle(1, 0, a_cmp(1), 0);
    cycle(1, 0, a_cmp(2), 12);
    cycle(1, 0, a_cmp(3), 5);
    cycle(1, 0, a_ctl(0), 'h28);
    cycle(1, 0, a_ctl(1), 'h28);
    cycle(1, 0, a_ctl(2), 'h28);
    cycle(1, 0, a_ctl(3), 'h24);
    cycle(0, 1, A_PER, 0); check(int'(rdata), 9, "R6", "period read back");
    check(int'(pwm_out), 'b0101, "R8", "stopped outputs at count 0");

    cur_req = "R2";
    cycle(1, 0, A_CFG, 'h28);
    cycle(0, 1, A_CFG, 0); check(int'(rdata), 'h08, "R2", "config bit 5 dropped");

    cur_req = "R4 R8 R9";
    idle(40);

    cur_req = "R7";
    cycle(1, 0, A_PER, 5);
    cycle(0, 1, A_PER, 0); check(int'(rdata), 5, "R7", "buffered period read");
    cycle(1, 0, a_cmp(0), 2);
    idle(30);

    cur_req = "R10 R11";
    cycle(1, 0, a_ctl(3), 'h2C);
    idle(1); check(int'(pwm_out[3]), 0, "R10", "reserved level code");
    cycle(1, 0, a_ctl(0), 'h08);
    idle(1); check(int'(pwm_out[0]), 0, "R11", "mode bit cleared acts next clock");
    cycle(1, 0, a_ctl(1), 'h10);
    idle(4);

    cur_req = "R12";
    cycle(1, 0, a_ctl(0), 'h28);
    idle(20);
    cycle(0, 1, a_ctl(0), 0); check(int'(rdata), 'hA8, "R12", "event flag set");
    cycle(1, 0, a_ctl(0), 'hA8);
    cycle(0, 1, a_ctl(0), 0);
    cycle(1, 0, a_ctl(0), 'h28);
    idle(8);

    cur_req = "R3";
    cycle(1, 0, A_CFG, 'h02);
    cycle(0, 1, A_CNT, 0); c1 = int'(rdata);
    idle(3);
    cycle(0, 1, A_CNT, 0); c2 = int'(rdata);
    check(c2, c1, "R3", "count held while stopped");
    cycle(1, 0, A_CFG, 'h0A);
    idle(60);
    cycle(1, 0, A_CFG, 'h0F);
    idle(800);

    cur_req = "R5";
    cycle(1, 0, A_CFG, 'h08);
    idle(3);
    cycle(1, 0, A_CNT, 0);
    cycle(0, 1, A_CNT, 0); check(int'(rdata), 0, "R5", "count write clears");
    idle(7);
    cycle(1, 0, A_CFG, 'h00);
    idle(2);
    cycle(1, 0, A_CFG, 'h08);
    cycle(0, 1, A_CNT, 0); check(int'(rdata), 0, "R5", "start clears count");

    cur_req = "R13";
    idle(12);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule